// File: doc/BRIEF.md
# Shift-Add Clarke Transform Unit

This unit maps two sampled phase currents of a three-phase motor onto the stationary two-axis frame. The first output axis (alpha) is the first phase current itself. The second axis (beta) is the weighted sum of the first current plus twice the second, scaled by the reciprocal of root three. Every value is a 16-bit signed Q14 word: bit 15 carries the sign, bit 14 is the one integer bit, bits 13..0 are the fraction, and +1.0 is 16'h4000.

The unit has no general multiplier. The constant is replaced by 591/1024, which is the sum of six power-of-two weights. Each weight is an arithmetic right shift of a widened copy of the phase sum, and a registered adder tree adds the six shifted terms. The unit is fully pipelined and accepts one sample on every clock. A small motor tag travels alongside each sample, so that several motors can share the unit in time. Results that do not fit in Q14 are clamped rather than wrapped.

Top module: `clarke_xform`

## Requirements
- R1: When outValid is high, outAlpha equals the inIa value that was accepted with that sample, bit for bit.
- R2: With s = inIa + 2*inIb taken as an exact integer, outBeta equals floor((s*591 + 512) / 1024), that is 591/1024 times s rounded half up, whenever that value lies in [-32768, 32767]. The floor rounds toward minus infinity, so negative s keeps its sign through every shift.
- R3: When the R2 value exceeds 32767, outBeta is 16'h7FFF. When it is below -32768, outBeta is 16'h8000. A positive s never gives a negative or zero beta, and a negative s never gives a non-negative beta.
- R4: outValid rises exactly 3 clock edges after the edge that samples inValid high. Back-to-back inputs give back-to-back outputs in the same order, with no gaps and no extra strobes.
- R5: outTag equals the inTag that was sampled with the same sample, and is delayed by the same 3 clocks.
- R6: While outValid is low, outAlpha, outBeta and outTag keep the values of the last valid result. Inputs that are sampled while inValid is low have no effect on the outputs.
- R7: While rstN is low, outValid is 0 and outAlpha, outBeta and outTag are all 0.
- R8: When outBeta is not clamped, it differs from s divided by the square root of three by no more than 0.00021*|s| + 1 LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Sample strobe for inIa, inIb and inTag |
| inIa | input | 16 | Phase a current, Q14 signed |
| inIb | input | 16 | Phase b current, Q14 signed |
| inTag | input | TAGW (3) | Motor number carried with the sample |
| outValid | output | 1 | Result strobe, 3 clocks after inValid |
| outAlpha | output | 16 | Alpha component, Q14 signed |
| outBeta | output | 16 | Beta component, Q14 signed, clamped |
| outTag | output | TAGW (3) | Motor number of the current result |

## Verification
A misaligned stage shows up as results that are paired with the wrong neighbour. The outAlpha or outTag of one sample then appears next to the outBeta of the one before, and this is visible at the very first back-to-back pair, 3 clocks after they enter. A dropped shift term or a logical shift in place of an arithmetic one moves outBeta off the exact 591/1024 value by a large amount. This error appears on the first negative or mid-range sample, and the sweep reaches such samples within a few dozen cycles. A clamp that wraps instead of saturating flips the sign of outBeta on the first sample whose phase sum is large.

// File: rtl/clarke_pkg.sv
package clarke_pkg;

  // Number of power-of-two weights that together form 591/1024.
  localparam int NTERM = 6;

  // Right-shift amount of each weight: 1/2 + 1/16 + 1/128 + 1/256 + 1/512 + 1/1024.
  localparam int SHIFT_TAB [NTERM] = '{1, 4, 7, 8, 9, 10};

  // Guard fraction bits added before shifting. This must be at least the largest
  // shift, so that every term is exact until the single final rounding.
  localparam int FRAC = 10;

  // Register stages from the input strobe to the output strobe.
  localparam int LAT = 3;

  // Per-stage load strobes from the control to the datapath.
  typedef struct packed {
    logic ldSum;
    logic ldTree;
    logic ldOut;
  } stageStb_t;

endpackage

// File: rtl/clarke_ctrl.sv
module clarke_ctrl
  import clarke_pkg::*;
#(
  parameter int TAGW = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [TAGW-1:0] inTag,
  output stageStb_t       stb,
  output logic            outValid,
  output logic [TAGW-1:0] outTag
);

  logic            vPipe   [LAT];
  logic [TAGW-1:0] tagPipe [LAT];

  // The first stage captures the input strobe and the tag.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vPipe[0]   <= 1'b0;
      tagPipe[0] <= '0;
    end else begin
      vPipe[0] <= inValid;
      if (inValid) tagPipe[0] <= inTag;
    end
  end

  // Later stages. Each tag register loads only when a sample moves into it.
  for (genvar i = 1; i < LAT; i++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rstN) begin
        vPipe[i]   <= 1'b0;
        tagPipe[i] <= '0;
      end else begin
        vPipe[i] <= vPipe[i-1];
        if (vPipe[i-1]) tagPipe[i] <= tagPipe[i-1];
      end
    end
  end

  always_comb begin
    stb.ldSum  = inValid;
    stb.ldTree = vPipe[0];
    stb.ldOut  = vPipe[1];
  end

  assign outValid = vPipe[LAT-1];
  assign outTag   = tagPipe[LAT-1];

endmodule

// File: rtl/clarke_dp.sv
module clarke_dp
  import clarke_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  stageStb_t            stb,
  input  logic signed [DW-1:0] ia,
  input  logic signed [DW-1:0] ib,
  output logic signed [DW-1:0] alpha,
  output logic signed [DW-1:0] beta
);

  localparam int SW    = DW + 2;          // width of ia + 2*ib
  localparam int AW    = SW + 1 + FRAC;   // widened term width
  localparam int TW    = AW + 2;          // final accumulator width
  localparam int NPAIR = (NTERM + 1) / 2;

  localparam logic signed [TW-1:0] ROUND  = TW'(1) <<< (FRAC - 1);
  localparam logic signed [TW-1:0] MAXVAL = TW'(2 ** (DW - 1) - 1);
  localparam logic signed [TW-1:0] MINVAL = -(TW'(2 ** (DW - 1)));

  // Stage 1: the phase sum, and alpha held in step with it.
  logic signed [SW-1:0] sum1;
  logic signed [DW-1:0] a1;
  logic signed [SW-1:0] iaX, ibX2;

  always_comb begin
    iaX  = {{2{ia[DW-1]}}, ia};
    ibX2 = {ib[DW-1], ib, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sum1 <= '0;
      a1   <= '0;
    end else if (stb.ldSum) begin
      sum1 <= iaX + ibX2;
      a1   <= ia;
    end
  end

  // Shifted terms, taken from the widened sum with the sign kept.
  logic signed [AW-1:0] extSum;
  logic signed [AW-1:0] term [NTERM];

  assign extSum = {sum1[SW-1], sum1, {FRAC{1'b0}}};

  for (genvar t = 0; t < NTERM; t++) begin : gTerm
    assign term[t] = extSum >>> SHIFT_TAB[t];
  end

  // Stage 2: pairwise sums of the terms, each one registered.
  logic signed [AW-1:0] pairReg [NPAIR];
  logic signed [DW-1:0] a2;

  for (genvar p = 0; p < NPAIR; p++) begin : gPair
    logic signed [AW-1:0] pairNext;
    if (2 * p + 1 < NTERM) begin : gTwo
      assign pairNext = term[2*p] + term[2*p+1];
    end else begin : gOne
      assign pairNext = term[2*p];
    end
    always_ff @(posedge clk) begin
      if (!rstN)           pairReg[p] <= '0;
      else if (stb.ldTree) pairReg[p] <= pairNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           a2 <= '0;
    else if (stb.ldTree) a2 <= a1;
  end

  // Stage 3: final add, round half up, then clamp.
  logic signed [TW-1:0] acc, rnd;
  logic signed [DW-1:0] betaNext;

  always_comb begin
    acc = ROUND;
    for (int p = 0; p < NPAIR; p++) acc = acc + TW'(pairReg[p]);
    rnd = acc >>> FRAC;
    if (rnd > MAXVAL)      betaNext = {1'b0, {(DW-1){1'b1}}};
    else if (rnd < MINVAL) betaNext = {1'b1, {(DW-1){1'b0}}};
    else                   betaNext = rnd[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alpha <= '0;
      beta  <= '0;
    end else if (stb.ldOut) begin
      alpha <= a2;
      beta  <= betaNext;
    end
  end

endmodule

// File: rtl/clarke_xform.sv
module clarke_xform
  import clarke_pkg::*;
#(
  parameter int DW   = 16,
  parameter int TAGW = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [DW-1:0]   inIa,
  input  logic [DW-1:0]   inIb,
  input  logic [TAGW-1:0] inTag,
  output logic            outValid,
  output logic [DW-1:0]   outAlpha,
  output logic [DW-1:0]   outBeta,
  output logic [TAGW-1:0] outTag
);

  stageStb_t stb;

  clarke_ctrl #(.TAGW(TAGW)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inTag    (inTag),
    .stb      (stb),
    .outValid (outValid),
    .outTag   (outTag)
  );

  clarke_dp #(.DW(DW)) uDp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .ia    (inIa),
    .ib    (inIb),
    .alpha (outAlpha),
    .beta  (outBeta)
  );

endmodule

// File: rtl/clarke_xform_chk.sv
module clarke_xform_chk #(
  parameter int DW   = 16,
  parameter int TAGW = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic            inValid,
  input logic [DW-1:0]   inIa,
  input logic [DW-1:0]   inIb,
  input logic [TAGW-1:0] inTag,
  input logic            outValid,
  input logic [DW-1:0]   outAlpha,
  input logic [DW-1:0]   outBeta,
  input logic [TAGW-1:0] outTag
);

  // Cycles since reset, saturating at 3, so that no $past reaches before reset.
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (!rstN)             warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  logic signed [DW+1:0] sumNow;
  assign sumNow = {{2{inIa[DW-1]}}, inIa} + {inIb[DW-1], inIb, 1'b0};

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3) |-> (outValid == $past(inValid, 3)));

  // R1
  alpha_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3 && outValid) |-> (outAlpha == $past(inIa, 3)));

  // R5
  tag_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3 && outValid) |-> (outTag == $past(inTag, 3)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm != 2'd0 && !outValid) |->
      ($stable(outAlpha) && $stable(outBeta) && $stable(outTag)));

  // R3
  pos_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3 && outValid && $past(sumNow, 3) > 0) |->
      (!outBeta[DW-1] && outBeta != '0));

  // R3
  neg_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3 && outValid && $past(sumNow, 3) < 0) |-> outBeta[DW-1]);

endmodule

bind clarke_xform clarke_xform_chk #(.DW(DW), .TAGW(TAGW)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inIa     (inIa),
  .inIb     (inIb),
  .inTag    (inTag),
  .outValid (outValid),
  .outAlpha (outAlpha),
  .outBeta  (outBeta),
  .outTag   (outTag)
);

// File: tb/sim_clarke_xform.sv
module sim_clarke_xform;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] inIa = '0;
  logic [15:0] inIb = '0;
  logic [2:0]  inTag = '0;
  logic        outValid;
  logic [15:0] outAlpha, outBeta;
  logic [2:0]  outTag;

  always #2.5 clk = ~clk;

  clarke_xform u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inIa(inIa), .inIb(inIb),
    .inTag(inTag), .outValid(outValid), .outAlpha(outAlpha),
    .outBeta(outBeta), .outTag(outTag)
  );

  typedef struct {
    int ia;
    int ib;
    int tag;
    int cyc;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;
  logic [15:0] lastA = '0, lastB = '0;
  logic [2:0]  lastT = '0;

  function automatic int expBeta(int ia, int ib, output bit sat);
    int s, r;
    s = ia + 2 * ib;
    r = (s * 591 + 512) >>> 10;
    sat = 0;
    if (r > 32767)  begin r = 32767;  sat = 1; end
    if (r < -32768) begin r = -32768; sat = 1; end
    return r;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d cyc=%0d", req, act, exp, cyc);
    end
  endtask

  task automatic checkOut();
    if (outValid) begin
      if (q.size() == 0) begin
        chk(0, "R4 unexpected outValid", 1, 0);
      end else begin
        item_t e;
        bit sat;
        int eb, ab;
        real exact, tol, diff;
        e = q.pop_front();
        chk(cyc == e.cyc + 3, "R4 latency", cyc - e.cyc, 3);
        chk($signed(outAlpha) == e.ia, "R1 alpha", $signed(outAlpha), e.ia);
        chk(int'(outTag) == e.tag, "R5 tag", outTag, e.tag);
        eb = expBeta(e.ia, e.ib, sat);
        ab = $signed(outBeta);
        chk(ab == eb, sat ? "R3 beta clamp" : "R2 beta value", ab, eb);
        if (!sat) begin
          exact = real'(e.ia + 2 * e.ib) / $sqrt(3.0);
          tol = 0.00021 * ((e.ia + 2 * e.ib) < 0 ? -(e.ia + 2 * e.ib) : (e.ia + 2 * e.ib)) + 1.0;
          diff = real'(ab) - exact;
          if (diff < 0.0) diff = -diff;
          chk(diff <= tol, "R8 accuracy", ab, $rtoi(exact));
        end
        lastA = outAlpha; lastB = outBeta; lastT = outTag;
      end
    end else begin
      chk(outAlpha == lastA && outBeta == lastB && outTag == lastT,
          "R6 hold", $signed(outBeta), $signed(lastB));
    end
  endtask

  task automatic step(bit v, int ia, int ib, int tag);
    item_t e;
    @(negedge clk);
    cyc++;
    checkOut();
    inValid = v;
    inIa = 16'(ia);
    inIb = 16'(ib);
    inTag = 3'(tag);
    if (v) begin
      e.ia = ia; e.ib = ib; e.tag = tag; e.cyc = cyc;
      q.push_back(e);
    end
  endtask

  initial begin : watchdog
    while (cyc < 150000 && !finished) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int n;
    // R7: reset state, with inputs that would load if reset were ignored
    repeat (2) @(negedge clk);
    inValid = 1'b1; inIa = 16'h1234; inIb = 16'h2345; inTag = 3'd5;
    repeat (4) @(negedge clk);
    chk(outValid == 1'b0, "R7 reset valid", outValid, 0);
    chk(outAlpha == 0 && outBeta == 0 && outTag == 0, "R7 reset data",
        outAlpha, 0);
    inValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;

    // Corners, back to back (R2, R3, R4)
    step(1, 0, 0, 0);
    step(1, 32767, 32767, 1);
    step(1, -32768, -32768, 2);
    step(1, -1, 0, 3);
    step(1, 1, 0, 4);
    step(1, 0, -1, 5);
    step(1, 16384, 0, 6);
    step(1, 0, 16384, 7);
    step(1, 32767, -16384, 0);
    step(1, -32768, 16383, 1);
    step(1, 16384, 8192, 2);
    step(1, -16384, -8192, 3);
    step(1, 1, -1, 4);

    // R6: idle cycles with garbage on the data inputs
    step(0, 12345, -5432, 6);
    step(0, -999, 777, 1);
    step(0, 31000, 31000, 7);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);

    // Near-exhaustive grid sweep (R1, R2, R3, R5, R8), with idle gaps
    n = 0;
    for (int a = -32768; a <= 32767; a += 1031) begin
      for (int b = -32768; b <= 32767; b += 1031) begin
        n++;
        if (n % 7 == 0) step(0, b, a, n);
        step(1, a, b, n % 8);
      end
    end

    // Small-magnitude sweep for sign and rounding (R2)
    for (int a = -20; a <= 20; a++) begin
      for (int b = -20; b <= 20; b += 3) step(1, a, b, (a + b) & 7);
    end

    repeat (5) step(0, 0, 0, 0);
    chk(q.size() == 0, "R4 all results returned", q.size(), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule